// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the 32-bit control register space of a host bridge. A single word offset selects one of 28 full-word registers. The same offset serves both writes and reads. A write is taken on the clock edge when the write enable is high. Read data follows the offset combinationally. The registers hold bridge configuration, GPIO settings, interrupt-controller setup, mailboxes, cache control and timing values. Only the register behaviour is modelled here. What the values control downstream is outside this block.

Two words behave differently from plain storage:

- **Interrupt enable word.** Software cannot write it directly. It changes only through a write-1-to-set alias and a write-1-to-clear alias. The interrupt status word is read-only.
- **General configuration word.** Writing it so that its reset-control bit goes from 0 to 1 raises a one-cycle system reset request.

Top module: `hbr_ctrl_regs`

## Requirements
- R1: Word offsets 0 to 27 (byte offsets 0x00 to 0x6C) each hold one full 32-bit word. A write at a plain storage offset stores the write data, and a later read at that offset returns it. A write at one offset leaves every other offset unchanged.
- R2: A write to the enable-set alias (word 12, byte 0x30) stores the data in word 12. It also ORs the data into the enable word (word 14, byte 0x38).
- R3: A write to the enable-clear alias (word 13, byte 0x34) stores the data in word 13. It also clears, in the enable word, every bit that is 1 in the data.
- R4: The enable word (word 14) and the interrupt status word (word 15, byte 0x3C) are read-only, and writes to them have no effect. The status word always reads 0. The enable word changes only through R2 and R3.
- R5: A write to the general configuration word (word 1, byte 0x04) raises the reset request when it changes bit 2 from 0 to 1. The written value is stored in full.
- R6: The reset request is high for exactly one cycle, in the cycle after the causing write. It stays low in two cases: the write data has bit 2 clear, or bit 2 of the general configuration word is already 1. A write to any other offset never raises it.
- R7: After reset, the non-zero words hold these values:

  | Word | Reset value |
  |---|---|
  | 0 | 0xC40 |
  | 1 | 0x1384 |
  | 2 | 0x2BFF8010 |
  | 3 | 0x255E0091 |
  | 4 | 0x6140 |
  | 7 | 0x1FF |
  | 8 | 0x1FF |
  | 26 | 0x8 |
  | 27 | 0x10000000 |

  Every other word resets to 0. Reset also returns modified words to these values.
- R8: Offsets 28 to 31 hold no register. Writes there change nothing, and reads there return 0.
- R9: The set and clear alias words (12 and 13) read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| offset | input | 5 | Word offset, shared by reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current offset |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 5-bit offset, 28 registers and bit 2 as the reset-control bit. With these values, offsets 28 to 31 exist in the address space but hold no register, so the out-of-range path (R8) can be tested. The bench exercises the reset-control edge from both starting states of bit 2: already set at reset, and cleared by software. The set and clear aliases are driven with overlapping masks, so the accumulated enable word shows whether each alias updates it correctly.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

   localparam int unsigned HBR_DW    = 32;
   localparam int unsigned IDX_GEN   = 1;
   localparam int unsigned IDX_ENSET = 12;
   localparam int unsigned IDX_ENCLR = 13;
   localparam int unsigned IDX_EN    = 14;
   localparam int unsigned IDX_ISR   = 15;

   typedef enum logic [1:0] {
      WK_PLAIN  = 2'd0,
      WK_ENABLE = 2'd1,
      WK_STATUS = 2'd2
   } word_kind_e;

   function automatic logic [HBR_DW-1:0] word_reset(input int unsigned idx);
      case (idx)
         0:       return 32'h0000_0C40;
         1:       return 32'h0000_1384;
         2:       return 32'h2BFF_8010;
         3:       return 32'h255E_0091;
         4:       return 32'h0000_6140;
         7:       return 32'h0000_01FF;
         8:       return 32'h0000_01FF;
         26:      return 32'h0000_0008;
         27:      return 32'h1000_0000;
         default: return '0;
      endcase
   endfunction

   function automatic word_kind_e word_kind(input int unsigned idx);
      if (idx == IDX_EN)  return WK_ENABLE;
      if (idx == IDX_ISR) return WK_STATUS;
      return WK_PLAIN;
   endfunction

endpackage

// File: rtl/hbr_decode.sv
module hbr_decode #(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned NUM_WORDS = 28
) (
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    offset,
   output logic [NUM_WORDS-1:0] wr_sel,
   output logic                 in_range
);
   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_sel
      assign wr_sel[i] = wr_en && (offset == ADDR_W'(i));
   end

   assign in_range = (32'(offset) < NUM_WORDS);
endmodule

// File: rtl/hbr_word.sv
module hbr_word #(
   parameter int unsigned       DATA_W = 32,
   parameter logic [DATA_W-1:0] RESET  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= RESET;
      else if (we) q <= d;
   end
endmodule

// File: rtl/hbr_irq_en.sv
module hbr_irq_en #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] set_mask;
   logic [DATA_W-1:0] clr_mask;

   assign set_mask = set_we ? d : '0;
   assign clr_mask = clr_we ? d : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q | set_mask) & ~clr_mask;
   end
endmodule

// File: rtl/hbr_rst_req.sv
module hbr_rst_req (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic cur_bit,
   input  logic new_bit,
   output logic pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= we && !cur_bit && new_bit;
   end
endmodule

// File: rtl/hbr_ctrl_regs.sv
module hbr_ctrl_regs #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned NUM_WORDS = 28,
   parameter int unsigned RST_BIT   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] offset,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              reset_req
);
   import hbr_pkg::*;

   localparam int unsigned SPAN = 1 << ADDR_W;

   if (DATA_W != HBR_DW) begin : g_chk_dw
      $error("hbr_ctrl_regs: DATA_W must equal the package word width");
   end
   if (NUM_WORDS > SPAN) begin : g_chk_span
      $error("hbr_ctrl_regs: NUM_WORDS does not fit in the offset");
   end
   if (NUM_WORDS <= IDX_ISR) begin : g_chk_cnt
      $error("hbr_ctrl_regs: NUM_WORDS too small for the interrupt words");
   end
   if (RST_BIT >= DATA_W) begin : g_chk_bit
      $error("hbr_ctrl_regs: RST_BIT outside the word");
   end

   logic [NUM_WORDS-1:0]             wr_sel;
   logic                             in_range;
   logic [NUM_WORDS-1:0][DATA_W-1:0] word_q;
   logic                             unused_sel;

   hbr_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
      .wr_en    (wr_en),
      .offset   (offset),
      .wr_sel   (wr_sel),
      .in_range (in_range)
   );

   assign unused_sel = ^{wr_sel[IDX_EN], wr_sel[IDX_ISR]};

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      localparam word_kind_e KIND = word_kind(i);
      if (KIND == WK_ENABLE) begin : g_en
         hbr_irq_en #(.DATA_W(DATA_W)) u_en (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (wr_sel[IDX_ENSET]),
            .clr_we (wr_sel[IDX_ENCLR]),
            .d      (wdata),
            .q      (word_q[i])
         );
      end else if (KIND == WK_STATUS) begin : g_ro
         assign word_q[i] = '0;
      end else begin : g_rw
         hbr_word #(.DATA_W(DATA_W), .RESET(word_reset(i))) u_w (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_sel[i]),
            .d     (wdata),
            .q     (word_q[i])
         );
      end
   end

   hbr_rst_req u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_sel[IDX_GEN]),
      .cur_bit (word_q[IDX_GEN][RST_BIT]),
      .new_bit (wdata[RST_BIT]),
      .pulse   (reset_req)
   );

   always_comb begin
      rdata = '0;
      if (in_range) begin
         for (int i = 0; i < NUM_WORDS; i++) begin
            if (offset == ADDR_W'(i)) rdata = word_q[i];
         end
      end
   end
endmodule

// File: rtl/hbr_ctrl_regs_chk.sv
module hbr_ctrl_regs_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned NUM_WORDS = 28,
   parameter int unsigned RST_BIT   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] offset,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              reset_req,
   input logic [DATA_W-1:0] en_q,
   input logic [DATA_W-1:0] gen_q
);
   import hbr_pkg::*;

   assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req);

   assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> ($past(wr_en && offset == ADDR_W'(IDX_GEN) && wdata[RST_BIT])
                     && !$past(gen_q[RST_BIT]) && gen_q[RST_BIT]));

   assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && offset == ADDR_W'(IDX_ENSET)) |=> ((en_q & $past(wdata)) == $past(wdata)));

   assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && offset == ADDR_W'(IDX_ENCLR)) |=> ((en_q & $past(wdata)) == '0));

   assert_en_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (offset == ADDR_W'(IDX_ENSET) || offset == ADDR_W'(IDX_ENCLR)))
      |=> $stable(en_q));

   assert_status_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (offset == ADDR_W'(IDX_ISR)) |-> (rdata == '0));

   assert_oor_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(offset) >= NUM_WORDS) |-> (rdata == '0));
endmodule

bind hbr_ctrl_regs hbr_ctrl_regs_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .RST_BIT(RST_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .offset    (offset),
   .wdata     (wdata),
   .rdata     (rdata),
   .reset_req (reset_req),
   .en_q      (word_q[hbr_pkg::IDX_EN]),
   .gen_q     (word_q[hbr_pkg::IDX_GEN])
);

// File: tb/hbr_ctrl_regs_tb_top.sv
module hbr_ctrl_regs_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  offset = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        reset_req;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   hbr_ctrl_regs dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .offset(offset),
      .wdata(wdata), .rdata(rdata), .reset_req(reset_req)
   );

   typedef struct {
      bit          is_req;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];

   function automatic logic [31:0] exp_reset(input int idx);
      case (idx)
         0: return 32'hC40;        1: return 32'h1384;
         2: return 32'h2BFF8010;   3: return 32'h255E0091;
         4: return 32'h6140;       7: return 32'h1FF;
         8: return 32'h1FF;        26: return 32'h8;
         27: return 32'h10000000;  default: return 32'h0;
      endcase
   endfunction

   task automatic wr(input int off, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; offset = 5'(off); wdata = d;
   endtask

   task automatic rd(input int off, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      wr_en = 1'b0; offset = 5'(off);
      it.is_req = 1'b0; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic req_chk(input bit e, input string tag);
      item_t it;
      @(negedge clk);
      wr_en = 1'b0;
      it.is_req = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
      sb_q.push_back(it);
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         #2;
         while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_req ? {31'b0, reset_req} : rdata;
            n_tests++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin : watchdog
      #(8 * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R7: reset values of every word
      for (int i = 0; i < 28; i++) rd(i, exp_reset(i), "R7");
      req_chk(1'b0, "R6");
      // R1: plain storage
      wr(2, 32'hDEAD_BEEF);
      wr(27, 32'h1234_5678);
      wr(5, 32'hA5A5_5A5A);
      rd(2, 32'hDEAD_BEEF, "R1");
      rd(27, 32'h1234_5678, "R1");
      rd(5, 32'hA5A5_5A5A, "R1");
      rd(3, 32'h255E0091, "R1");
      // R8: out-of-range offsets
      wr(28, 32'hFFFF_FFFF);
      wr(31, 32'h0BAD_F00D);
      rd(28, 32'h0, "R8");
      rd(31, 32'h0, "R8");
      rd(0, 32'hC40, "R8");
      rd(27, 32'h1234_5678, "R8");
      // R2 / R9: set alias
      wr(12, 32'h0000_00F0);
      rd(14, 32'h0000_00F0, "R2");
      rd(12, 32'h0000_00F0, "R9");
      wr(12, 32'h0F00_0001);
      rd(14, 32'h0F00_00F1, "R2");
      // R3 / R9: clear alias
      wr(13, 32'h0000_00F0);
      rd(14, 32'h0F00_0001, "R3");
      rd(13, 32'h0000_00F0, "R9");
      // R4: read-only words
      wr(14, 32'hFFFF_FFFF);
      rd(14, 32'h0F00_0001, "R4");
      wr(15, 32'hFFFF_FFFF);
      rd(15, 32'h0, "R4");
      wr(13, 32'hFFFF_FFFF);
      rd(14, 32'h0, "R3");
      // R5 / R6: reset request
      wr(1, 32'h0000_1384);
      req_chk(1'b0, "R6");
      wr(1, 32'h0000_1380);
      req_chk(1'b0, "R6");
      wr(1, 32'h0000_1380);
      req_chk(1'b0, "R6");
      wr(1, 32'hF000_0004);
      req_chk(1'b1, "R5");
      req_chk(1'b0, "R6");
      rd(1, 32'hF000_0004, "R5");
      wr(1, 32'h0000_0004);
      req_chk(1'b0, "R6");
      wr(0, 32'h0000_0000);
      wr(0, 32'h0000_0004);
      req_chk(1'b0, "R6");
      // R7: reset restores modified words
      @(negedge clk);
      wr_en = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(2, 32'h2BFF8010, "R7");
      rd(1, 32'h1384, "R7");
      rd(14, 32'h0, "R7");
      rd(12, 32'h0, "R7");
      req_chk(1'b0, "R7");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule